// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block collects fifteen interrupt sources and presents one request at a time to a processor core. Four sources come from external pins. Each pin has its own trigger mode. The other eleven are internal one-cycle set pulses from peripherals. The sources are folded onto ten vector slots. The four pin sources each own a vector. The eleven internal sources share the remaining six vectors in pairs, and software tells the two sources of a vector apart through the per-source pending flags.

Each vector carries an enable bit and a two-bit priority code. The code selects one of three service levels. The arbiter picks the eligible vector with the highest level, and on a tie it picks the lowest vector index. A vector is eligible only when its level is strictly above the level now in service, so a running handler can be interrupted only by a more urgent one. The processor acknowledges the presented vector with a strobe, which records the new service level. It signals the end of a handler with a return strobe, which restores the level that was in service before.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the service level is 0, no request is presented, and every latched pending flag is clear.
- R2: Pin p (p = 0..3) is source p and maps to vector p. Internal set input k (k = 0..10) is source 4+k and maps to vector 4 + k/2 (integer division). A vector requests while any of its sources is pending.
- R3: A pulse on internal set input k makes srcFlags[4+k] read 1 after the next rising clock edge. The flag then stays set until its vector is acknowledged. When a set and an acknowledge clear land on the same edge, the set wins.
- R4: Pins 0 and 1 take a 2-bit mode code: 00 = rising edge, 01 = falling edge, 10 = high level, 11 = low level. A pin sample is taken on each clock edge. A level condition shows in srcFlags from that edge on. An edge is latched one edge later.
- R5: Pins 2 and 3 take a 2-bit mode code: 00 = rising edge, 01 = falling edge, 10 or 11 = both edges. These pins never raise a level-held request.
- R6: Priority code 00 means level 1 (low), 01 means level 2 (high), and 10 or 11 means level 3 (highest). A vector whose enable bit is 0 never wins, but its sources still record pending flags.
- R7: Among eligible vectors the highest level wins, and equal levels go to the lowest vector index. irqVec reads 0 when no request is presented.
- R8: A vector is eligible only when its level is strictly greater than the current service level.
- R9: An acknowledge while a request is presented does two things at the next edge. It makes the winner's level the service level. It also clears the latched edge flags of all sources of the winning vector. An acknowledge with no request presented changes nothing.
- R10: A return strobe restores the previous service level, or 0 when only one level was in service. A return is ignored when nothing is in service, and it is also ignored in any cycle where the acknowledge strobe is high.
- R11: A level-triggered pin request is not cleared by an acknowledge. It stays pending for as long as the level condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 4 | Raw levels of the external interrupt pins |
| pinMode | input | 8 | Trigger mode code per pin, two bits each, pin p at bits 2p+1:2p |
| srcSet | input | 11 | One-cycle set pulses of the internal sources |
| vecEn | input | 10 | Per-vector enable |
| vecPrio | input | 20 | Priority code per vector, vector v at bits 2v+1:2v |
| ackStrobe | input | 1 | Processor accepts the presented vector |
| retStrobe | input | 1 | Processor leaves the current handler |
| irqReq | output | 1 | A vector is presented to the processor |
| irqVec | output | 4 | Index of the presented vector |
| svcLevel | output | 2 | Service level now running (0 = none) |
| srcFlags | output | 15 | Per-source pending flags |

## Verification
The bound assertions check, on every cycle, that a presented vector is enabled and ranks above the level in service. They also check how the service level reacts to acknowledge and return strobes, including the cases where either strobe must be ignored, and that every internal set pulse shows up as a pending flag. Other behaviours depend on history across many cycles, and only the bench scenarios can show them. These are the tie-break by index, the pairing of sources onto shared vectors, each pin trigger mode with its one- or two-edge latency, level requests that survive an acknowledge, and a set that collides with a clear. The bench's reference model follows random mixes of all of these cycle by cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Source and vector counts
  parameter int NUM_PIN    = 4;   // external pins, one vector each
  parameter int LEVEL_PINS = 2;   // pins 0..LEVEL_PINS-1 support level triggers
  parameter int NUM_SRC    = 15;  // all sources
  parameter int SHARE      = 2;   // internal sources per shared vector
  parameter int LEVEL_N    = 3;   // number of service levels

  localparam int NUM_INT = NUM_SRC - NUM_PIN;
  localparam int NUM_VEC = NUM_PIN + (NUM_INT + SHARE - 1) / SHARE;
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int LVL_W   = $clog2(LEVEL_N + 1);

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [LEVEL_N-1:0] lvlMask_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic               push;
    logic               pop;
    lvl_t               pushLvl;
    logic [NUM_VEC-1:0] clrVec;
  } strobe_t;

  // R2: source to vector folding
  function automatic int vecOf(int s);
    return (s < NUM_PIN) ? s : NUM_PIN + (s - NUM_PIN) / SHARE;
  endfunction

  function automatic logic [NUM_SRC-1:0] srcMaskOf(int v);
    logic [NUM_SRC-1:0] m;
    for (int s = 0; s < NUM_SRC; s++) m[s] = (vecOf(s) == v);
    return m;
  endfunction

  // R6: priority code to service level
  function automatic lvl_t prioToLevel(logic [1:0] code);
    case (code)
      2'b00:   return lvl_t'(1);
      2'b01:   return lvl_t'(2);
      default: return lvl_t'(3);
    endcase
  endfunction
endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PIN-1:0]   pinIn,
  input  logic [2*NUM_PIN-1:0] pinMode,
  input  logic [NUM_INT-1:0]   srcSet,
  input  strobe_t              stb,
  output logic [NUM_SRC-1:0]   srcFlags,
  output logic [NUM_VEC-1:0]   vecReq,
  output lvl_t                 svcLevel
);
  logic [NUM_PIN-1:0] pinQ, pinPrev, pinEvt, pinLvl;
  logic [NUM_SRC-1:0] edgeFlag, setHit, clrHit;
  lvlMask_t           svcMask, topBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ    <= '0;
      pinPrev <= '0;
    end else begin
      pinQ    <= pinIn;
      pinPrev <= pinQ;
    end
  end

  // R4, R5: per-pin trigger decoding
  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    logic [1:0] mode;
    logic       rise, fall;
    assign mode = pinMode[2*p +: 2];
    assign rise = pinQ[p] & ~pinPrev[p];
    assign fall = ~pinQ[p] & pinPrev[p];
    if (p < LEVEL_PINS) begin : g_lvlPin
      assign pinEvt[p] = (mode == 2'b00) ? rise :
                         (mode == 2'b01) ? fall : 1'b0;
      assign pinLvl[p] = (mode == 2'b10) ? pinQ[p] :
                         (mode == 2'b11) ? ~pinQ[p] : 1'b0;
    end else begin : g_edgePin
      assign pinEvt[p] = (mode == 2'b00) ? rise :
                         (mode == 2'b01) ? fall : (rise | fall);
      assign pinLvl[p] = 1'b0;
    end
  end

  assign setHit = {srcSet, pinEvt};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
    assign clrHit[s] = stb.clrVec[vecOf(s)];
  end

  // R3: set has precedence over acknowledge clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeFlag <= '0;
    else       edgeFlag <= (edgeFlag & ~clrHit) | setHit;
  end

  // R11: level requests bypass the latch
  assign srcFlags = edgeFlag | {{NUM_INT{1'b0}}, pinLvl};

  // R2: OR of the sources of each vector
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vecReq[v] = |(srcFlags & srcMaskOf(v));
  end

  // In-service record: levels nest strictly upward, so one bit per level
  always_comb begin
    svcLevel = '0;
    topBit   = '0;
    for (int i = 0; i < LEVEL_N; i++) begin
      if (svcMask[i]) begin
        svcLevel = lvl_t'(i + 1);
        topBit   = lvlMask_t'(1) << i;
      end
    end
  end

  // R9, R10
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        svcMask <= '0;
    else if (stb.push) svcMask <= svcMask | (lvlMask_t'(1) << (stb.pushLvl - lvl_t'(1)));
    else if (stb.pop)  svcMask <= svcMask & ~topBit;
  end
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic [NUM_VEC-1:0]   vecReq,
  input  logic [NUM_VEC-1:0]   vecEn,
  input  logic [2*NUM_VEC-1:0] vecPrio,
  input  lvl_t                 svcLevel,
  input  logic                 ackStrobe,
  input  logic                 retStrobe,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVec,
  output strobe_t              stb
);
  lvl_t               vecLvl [NUM_VEC];
  logic [NUM_VEC-1:0] elig;
  lvl_t               bestLvl;
  logic [VEC_W-1:0]   bestIdx;

  // R6, R8: eligibility
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_elig
    assign vecLvl[v] = prioToLevel(vecPrio[2*v +: 2]);
    assign elig[v]   = vecReq[v] & vecEn[v] & (vecLvl[v] > svcLevel);
  end

  // R7: scan downward so equal levels settle on the lowest index
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (elig[v] && vecLvl[v] >= bestLvl) begin
        bestLvl = vecLvl[v];
        bestIdx = VEC_W'(v);
      end
    end
  end

  assign irqReq = |elig;
  assign irqVec = bestIdx;

  // R9, R10: handshake decisions
  always_comb begin
    stb.push    = ackStrobe & irqReq;
    stb.pop     = retStrobe & ~ackStrobe & (svcLevel != '0);
    stb.pushLvl = bestLvl;
    stb.clrVec  = stb.push ? (NUM_VEC'(1) << bestIdx) : '0;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PIN-1:0]   pinIn,
  input  logic [2*NUM_PIN-1:0] pinMode,
  input  logic [NUM_INT-1:0]   srcSet,
  input  logic [NUM_VEC-1:0]   vecEn,
  input  logic [2*NUM_VEC-1:0] vecPrio,
  input  logic                 ackStrobe,
  input  logic                 retStrobe,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVec,
  output logic [LVL_W-1:0]     svcLevel,
  output logic [NUM_SRC-1:0]   srcFlags
);
  strobe_t            stb;
  logic [NUM_VEC-1:0] vecReq;
  lvl_t               svcLvlInt;

  irq_arb_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .pinMode (pinMode),
    .srcSet  (srcSet),
    .stb     (stb),
    .srcFlags(srcFlags),
    .vecReq  (vecReq),
    .svcLevel(svcLvlInt)
  );

  irq_arb_control u_ctl (
    .vecReq   (vecReq),
    .vecEn    (vecEn),
    .vecPrio  (vecPrio),
    .svcLevel (svcLvlInt),
    .ackStrobe(ackStrobe),
    .retStrobe(retStrobe),
    .irqReq   (irqReq),
    .irqVec   (irqVec),
    .stb      (stb)
  );

  assign svcLevel = svcLvlInt;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_INT-1:0]   srcSet,
  input logic [NUM_VEC-1:0]   vecEn,
  input logic [2*NUM_VEC-1:0] vecPrio,
  input logic                 ackStrobe,
  input logic                 retStrobe,
  input logic                 irqReq,
  input logic [VEC_W-1:0]     irqVec,
  input logic [LVL_W-1:0]     svcLevel,
  input logic [NUM_SRC-1:0]   srcFlags
);
  lvl_t winLvl;
  assign winLvl = prioToLevel(vecPrio[int'(irqVec)*2 +: 2]);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (svcLevel == '0 && srcFlags[NUM_SRC-1:NUM_PIN] == '0));

  // R8
  above_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (winLvl > svcLevel));

  // R6
  enabled_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> vecEn[irqVec]);

  // R9
  ack_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && irqReq) |=> (svcLevel == $past(winLvl)));

  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !irqReq) |=> $stable(svcLevel));

  // R10
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !ackStrobe && svcLevel != '0) |=> (svcLevel < $past(svcLevel)));

  // R10
  ret_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !ackStrobe && svcLevel == '0) |=> (svcLevel == '0));

  // R3
  for (genvar k = 0; k < NUM_INT; k++) begin : g_set
    set_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      srcSet[k] |=> srcFlags[NUM_PIN + k]);
  end
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .srcSet   (srcSet),
  .vecEn    (vecEn),
  .vecPrio  (vecPrio),
  .ackStrobe(ackStrobe),
  .retStrobe(retStrobe),
  .irqReq   (irqReq),
  .irqVec   (irqVec),
  .svcLevel (svcLevel),
  .srcFlags (srcFlags)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  pinIn = '0;
  logic [7:0]  pinMode = '0;
  logic [10:0] srcSet = '0;
  logic [9:0]  vecEn = '1;
  logic [19:0] vecPrio = '0;
  logic        ackStrobe = 1'b0;
  logic        retStrobe = 1'b0;
  logic        irqReq;
  logic [3:0]  irqVec;
  logic [1:0]  svcLevel;
  logic [14:0] srcFlags;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinMode(pinMode), .srcSet(srcSet),
    .vecEn(vecEn), .vecPrio(vecPrio), .ackStrobe(ackStrobe), .retStrobe(retStrobe),
    .irqReq(irqReq), .irqVec(irqVec), .svcLevel(svcLevel), .srcFlags(srcFlags)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit mFlag [15];
  bit mQ [4];
  bit mPrev [4];
  int mStack [$];

  function automatic int vOf(int s);
    if (s < 4) return s;
    return 4 + (s - 4) / 2;
  endfunction

  function automatic int lvlOf(int v);
    logic [1:0] c = vecPrio[2*v +: 2];
    if (c == 2'b00) return 1;
    if (c == 2'b01) return 2;
    return 3;
  endfunction

  function automatic bit lvlHit(int p);
    logic [1:0] m = pinMode[2*p +: 2];
    if (p >= 2) return 0;
    if (m == 2'b10) return mQ[p];
    if (m == 2'b11) return !mQ[p];
    return 0;
  endfunction

  function automatic bit evHit(int p);
    logic [1:0] m = pinMode[2*p +: 2];
    bit r = mQ[p] && !mPrev[p];
    bit f = !mQ[p] && mPrev[p];
    if (m == 2'b00) return r;
    if (m == 2'b01) return f;
    if (p < 2) return 0;
    return r || f;
  endfunction

  function automatic void mOut(output bit r, output int v, output int l, output logic [14:0] fl);
    int best = -1;
    int bestL = 0;
    l = (mStack.size() > 0) ? mStack[$] : 0;
    for (int s = 0; s < 15; s++) fl[s] = mFlag[s] || (s < 4 && lvlHit(s));
    for (int vv = 0; vv < 10; vv++) begin
      bit vr = 0;
      for (int s = 0; s < 15; s++) if (vOf(s) == vv && fl[s]) vr = 1;
      if (vr && vecEn[vv] && lvlOf(vv) > l && lvlOf(vv) > bestL) begin
        best = vv;
        bestL = lvlOf(vv);
      end
    end
    r = (best >= 0);
    v = r ? best : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 15; s++) mFlag[s] = 0;
      for (int p = 0; p < 4; p++) begin mQ[p] = 0; mPrev[p] = 0; end
      mStack.delete();
    end else begin
      bit r; int v; int l; logic [14:0] fl;
      bit clr [15];
      bit st [15];
      mOut(r, v, l, fl);
      for (int s = 0; s < 15; s++) begin
        clr[s] = 0;
        st[s] = (s < 4) ? evHit(s) : srcSet[s-4];
      end
      if (ackStrobe) begin
        if (r) begin
          mStack.push_back(lvlOf(v));
          for (int s = 0; s < 15; s++) if (vOf(s) == v) clr[s] = 1;
        end
      end else if (retStrobe && mStack.size() > 0) begin
        void'(mStack.pop_back());
      end
      for (int s = 0; s < 15; s++) mFlag[s] = (mFlag[s] && !clr[s]) || st[s];
      for (int p = 0; p < 4; p++) begin mPrev[p] = mQ[p]; mQ[p] = pinIn[p]; end
    end
  end

  // cycle-by-cycle comparison, mid high phase
  always @(posedge clk) begin
    #3;
    if (rstN && !done) begin
      bit r; int v; int l; logic [14:0] fl;
      mOut(r, v, l, fl);
      check("R8 model irqReq", 32'(irqReq), 32'(r));
      check("R7 model irqVec", 32'(irqVec), 32'(v));
      check("R10 model svcLevel", 32'(svcLevel), 32'(l));
      check("R3 model srcFlags", 32'(srcFlags), 32'(fl));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulseSet(int k);
    srcSet[k] = 1'b1;
    step();
    srcSet = '0;
  endtask

  task automatic doAck();
    ackStrobe = 1'b1;
    step();
    ackStrobe = 1'b0;
  endtask

  task automatic doRet();
    retStrobe = 1'b1;
    step();
    retStrobe = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 svcLevel", 32'(svcLevel), 0);
    check("R1 srcFlags", 32'(srcFlags), 0);
    rstN = 1'b1;
    step();

    // R6 disabled vector records but does not win; R2 mapping
    vecEn[5] = 1'b0;
    pulseSet(2);
    check("R6 flag recorded while disabled", 32'(srcFlags[6]), 1);
    check("R6 disabled no request", 32'(irqReq), 0);
    vecEn[5] = 1'b1;
    #1;
    check("R2 source 6 on vector 5 req", 32'(irqReq), 1);
    check("R2 source 6 on vector 5 vec", 32'(irqVec), 5);
    pulseSet(3);
    check("R2 shared partner flag", 32'(srcFlags[7]), 1);
    doAck();
    check("R9 level after ack", 32'(svcLevel), 1);
    check("R3 shared flags cleared", 32'(srcFlags[7:6]), 0);
    check("R9 nothing left", 32'(irqReq), 0);
    doRet();
    check("R10 back to idle", 32'(svcLevel), 0);

    // R7 tie-break and priority order
    pulseSet(0);
    pulseSet(10);
    check("R7 tie lowest index", 32'(irqVec), 4);
    vecPrio[19:18] = 2'b01;
    #1;
    check("R7 higher level wins", 32'(irqVec), 9);
    doAck();
    check("R9 level two", 32'(svcLevel), 2);
    check("R8 low held off", 32'(irqReq), 0);
    vecPrio[9:8] = 2'b11;
    #1;
    check("R6 code 11 highest req", 32'(irqReq), 1);
    check("R6 code 11 highest vec", 32'(irqVec), 4);
    doAck();
    check("R9 level three", 32'(svcLevel), 3);
    doRet();
    check("R10 restore level two", 32'(svcLevel), 2);
    doRet();
    check("R10 restore idle", 32'(svcLevel), 0);
    doRet();
    check("R10 return when idle", 32'(svcLevel), 0);
    doAck();
    check("R9 ack with no request", 32'(svcLevel), 0);
    vecPrio = '0;

    // R10 acknowledge and return together
    pulseSet(8);
    ackStrobe = 1'b1;
    retStrobe = 1'b1;
    step();
    ackStrobe = 1'b0;
    retStrobe = 1'b0;
    check("R10 return ignored with ack", 32'(svcLevel), 1);
    doRet();
    check("R10 single return", 32'(svcLevel), 0);

    // R3 set wins over clear
    pulseSet(4);
    check("R2 source 8 on vector 6", 32'(irqVec), 6);
    ackStrobe = 1'b1;
    srcSet[5] = 1'b1;
    step();
    ackStrobe = 1'b0;
    srcSet = '0;
    check("R3 acked flag cleared", 32'(srcFlags[8]), 0);
    check("R3 set beats clear", 32'(srcFlags[9]), 1);
    doRet();
    doAck();
    doRet();
    check("R3 all cleared", 32'(srcFlags), 0);

    // R4 pin 0 high level, R11
    pinMode[1:0] = 2'b10;
    pinIn[0] = 1'b1;
    step();
    check("R4 high level pending", 32'(srcFlags[0]), 1);
    check("R4 pin vector", 32'(irqVec), 0);
    doAck();
    check("R11 level survives ack", 32'(srcFlags[0]), 1);
    check("R11 in service", 32'(svcLevel), 1);
    doRet();
    pinIn[0] = 1'b0;
    step();
    check("R4 level gone", 32'(srcFlags[0]), 0);
    pinMode[1:0] = 2'b11;
    #1;
    check("R4 low level pending", 32'(srcFlags[0]), 1);
    pinMode[1:0] = 2'b00;
    #1;
    check("R4 rising mode idle", 32'(srcFlags[0]), 0);

    // R4 pin 1 falling edge
    pinMode[3:2] = 2'b01;
    pinIn[1] = 1'b1;
    step();
    step();
    check("R4 rise ignored in fall mode", 32'(srcFlags[1]), 0);
    pinIn[1] = 1'b0;
    step();
    step();
    check("R4 fall latched", 32'(srcFlags[1]), 1);
    doAck();
    check("R9 edge flag cleared", 32'(srcFlags[1]), 0);
    doRet();

    // R5 pin 2 both edges, pin 3 rising
    pinMode[5:4] = 2'b10;
    pinIn[2] = 1'b1;
    step();
    step();
    check("R5 both rise", 32'(srcFlags[2]), 1);
    doAck();
    check("R5 no level hold", 32'(srcFlags[2]), 0);
    doRet();
    pinIn[2] = 1'b0;
    step();
    step();
    check("R5 both fall", 32'(srcFlags[2]), 1);
    doAck();
    doRet();
    pinIn[3] = 1'b1;
    step();
    step();
    check("R5 pin 3 rise", 32'(srcFlags[3]), 1);
    doAck();
    doRet();
    pinIn[3] = 1'b0;
    step();
    step();
    check("R5 pin 3 fall ignored", 32'(srcFlags[3]), 0);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      srcSet = ($urandom_range(0, 3) == 0) ? 11'($urandom) & 11'($urandom) : '0;
      if ($urandom_range(0, 3) == 0) pinIn = 4'($urandom);
      if ($urandom_range(0, 15) == 0) pinMode = 8'($urandom);
      if ($urandom_range(0, 15) == 0) vecPrio = 20'($urandom);
      if ($urandom_range(0, 15) == 0) vecEn = 10'($urandom) | 10'($urandom);
      ackStrobe = ($urandom_range(0, 3) == 0);
      retStrobe = ($urandom_range(0, 4) == 0);
      step();
    end
    srcSet = '0;
    ackStrobe = 1'b0;
    retStrobe = 1'b0;
    step();
    finishRun();
  end
endmodule